// File: doc/BRIEF.md
# Serial Control Register Port

This block is a synchronous serial slave that lets a host read and write a small bank of eight-bit configuration registers over four wires: an active-low chip select, a serial clock, serial data in and serial data out. The host lowers chip select and sends a command byte. It then sends or receives one data byte for a single access, or every register in turn for a burst access. Raising chip select ends the transaction at any point.

All three host inputs pass through two-flop synchronizers into the system clock domain. Serial clock edges are detected there, so the register bank and the controller live entirely on `clk`. The serial clock therefore has to run well below the system clock; the bench uses eight system cycles per serial half period.

The highest register is a read-only status register. Reading it returns the `status_in` input, and no flop stores it. The other registers appear in parallel on `cfg_regs`. Tri-state is modelled by the `sdo_oe` enable.

The controller has five states:
- `ST_IDLE`: chip select is high. It moves to `ST_CMD` once chip select is low.
- `ST_CMD`: shifts the command byte. After the eighth bit it moves to `ST_WDATA` (write) or `ST_RDATA` (read).
- `ST_WDATA` and `ST_RDATA`: move data bytes. They go to `ST_DONE` after the only byte of a single access, or after the last register of a burst.
- `ST_DONE`: ignores further clocks.

From every state, a high chip select returns the controller to `ST_IDLE`.

Top module: `serial_reg_port`

## Requirements
- R1: The command byte is shifted least significant bit first. Bit 0 is the direction (0 = write, 1 = read). Bits 1..4 are the register address, with bit 1 as the address LSB. Bits 5 and 6 are reserved. Bit 7 is the burst flag.
- R2: A single write stores the data byte, received LSB first, in the addressed register only. Byte i of `cfg_regs` (bits 8i+7..8i) shows register i.
- R3: A single read presents the addressed register LSB first on `sdo`. `sdo` changes only on a falling serial clock edge, so the host samples it on the rising edge of each data bit.
- R4: `sdo_oe` stays low through the command byte, through any write, and while chip select is high. For a read, it rises at the first data bit.
- R5: A write command with bit 7 set, address 0 and reserved bits 0 is a burst write. Consecutive data bytes go to registers 0, 1, … up to 13.
- R6: A read command with the same burst encoding returns registers 0 through 13 in order.
- R7: A command with either reserved bit set, or with bit 7 set and a nonzero address, still counts its bits but changes no register. A read with such a command returns 0x00.
- R8: A single access to address 14 or 15 changes no register, and a read of it returns 0x00.
- R9: Register 13 is read-only. A read returns `status_in`, writes to it are ignored, and its byte in `cfg_regs` is 0x00.
- R10: Raising chip select in mid-transfer discards the partial byte, keeps the registers already written in a burst, and drops `sdo_oe`.
- R11: After reset, every register is 0x00 and `sdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| status_in | input | 8 | Value returned by the read-only register |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for `sdo` |
| cfg_regs | output | 112 | All registers in parallel, register i in bits 8i+7..8i |

## Verification
Several properties are checked every cycle by assertions:
- `sdo` holds its value between falling serial clock edges.
- The output enable stays off in the command and write phases, and after chip select rises.
- The bank changes only on a write strobe.
- A write strobe never targets the read-only or unmapped addresses.

Whether each byte lands in the right register, the order of a burst, the value of a read, the rejection of malformed commands and what survives an aborted burst can only be shown by the bench scenarios, which compare serial read-back and `cfg_regs` against values computed from the requirements.

// File: rtl/srp_pkg.sv
package srp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WDATA,
        ST_RDATA,
        ST_DONE
    } srp_state_e;

    // fixed command byte field positions
    localparam int CMD_RW_BIT    = 0;
    localparam int CMD_ADDR_LSB  = 1;
    localparam int CMD_RSV_LO    = 5;
    localparam int CMD_RSV_HI    = 6;
    localparam int CMD_BURST_BIT = 7;

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
    parameter int               STAGES  = 2,
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[g]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_in[g]};
            end
        end

        assign sync_out[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/srp_regbank.sv
module srp_regbank #(
    parameter int NREG       = 14,
    parameter int DW         = 8,
    parameter int ADDR_W     = 4,
    parameter int STATUS_IDX = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ADDR_W-1:0]  waddr,
    input  logic [DW-1:0]      wdata,
    input  logic [ADDR_W-1:0]  raddr,
    input  logic [DW-1:0]      status_in,
    output logic [DW-1:0]      rd_data,
    output logic [NREG*DW-1:0] regs_flat
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == STATUS_IDX) begin : g_status
            // read-only slot: no storage
            assign regs_flat[i*DW +: DW] = '0;
        end else begin : g_store
            logic [DW-1:0] val_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= '0;
                end else if (we && (waddr == ADDR_W'(i))) begin
                    val_q <= wdata;
                end
            end

            assign regs_flat[i*DW +: DW] = val_q;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NREG; k++) begin
            if (raddr == ADDR_W'(k)) begin
                rd_data = (k == STATUS_IDX) ? status_in : regs_flat[k*DW +: DW];
            end
        end
    end

    // R2: storage moves only under a write strobe
    a_r2_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs_flat));

endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
    import srp_pkg::*;
#(
    parameter int NREG       = 14,
    parameter int DW         = 8,
    parameter int ADDR_W     = 4,
    parameter int STATUS_IDX = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic [DW-1:0]     rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [DW-1:0]     wdata,
    output logic              sdo,
    output logic              sdo_oe
);

    localparam int                CNT_W     = $clog2(DW);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NREG - 1);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STATUS_IDX);

    srp_state_e        state_q, state_d;
    logic              sclk_d_q;
    logic [CNT_W-1:0]  bit_q;
    logic [DW-1:0]     sh_q;
    logic [DW-1:0]     rd_sh_q;
    logic [ADDR_W-1:0] addr_q;
    logic              burst_q;
    logic              bad_q;
    logic              we_q;
    logic [ADDR_W-1:0] waddr_q;
    logic [DW-1:0]     wdata_q;
    logic              sdo_q;
    logic              oe_q;

    logic              cs_active, sclk_rise, sclk_fall;
    logic              shifting, byte_done, at_last;
    logic [DW-1:0]     shifted;
    logic              c_rw, c_rsv, c_burst, c_bad;
    logic [ADDR_W-1:0] c_addr;

    assign cs_active = !cs_n_s;
    assign sclk_rise = sclk_s && !sclk_d_q;
    assign sclk_fall = !sclk_s && sclk_d_q;
    assign shifting  = (state_q == ST_CMD) || (state_q == ST_WDATA) || (state_q == ST_RDATA);
    assign byte_done = sclk_rise && shifting && (bit_q == CNT_W'(DW - 1));
    assign shifted   = {sdi_s, sh_q[DW-1:1]};
    assign at_last   = (addr_q == LAST_ADDR);

    // command decode of the byte completing this cycle
    assign c_rw    = shifted[CMD_RW_BIT];
    assign c_addr  = shifted[CMD_ADDR_LSB +: ADDR_W];
    assign c_rsv   = shifted[CMD_RSV_LO] | shifted[CMD_RSV_HI];
    assign c_burst = shifted[CMD_BURST_BIT];
    assign c_bad   = c_rsv
                   || (c_burst && (c_addr != '0))
                   || (!c_burst && (int'(c_addr) >= NREG));

    assign rd_addr = (state_q == ST_CMD) ? c_addr : addr_q + 1'b1;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!cs_active) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_CMD;
                ST_CMD:   if (byte_done) state_d = c_rw ? ST_RDATA : ST_WDATA;
                ST_WDATA: if (byte_done && (!burst_q || at_last)) state_d = ST_DONE;
                ST_RDATA: if (byte_done && (!burst_q || at_last)) state_d = ST_DONE;
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d_q <= 1'b0;
            bit_q    <= '0;
            sh_q     <= '0;
            rd_sh_q  <= '0;
            addr_q   <= '0;
            burst_q  <= 1'b0;
            bad_q    <= 1'b0;
            we_q     <= 1'b0;
            waddr_q  <= '0;
            wdata_q  <= '0;
            sdo_q    <= 1'b0;
            oe_q     <= 1'b0;
        end else begin
            sclk_d_q <= sclk_s;
            we_q     <= 1'b0;
            if (!cs_active) begin
                bit_q   <= '0;
                sh_q    <= '0;
                burst_q <= 1'b0;
                bad_q   <= 1'b0;
                oe_q    <= 1'b0;
            end else begin
                if (sclk_rise && shifting) begin
                    bit_q <= bit_q + 1'b1;
                    sh_q  <= shifted;
                end
                if (byte_done) begin
                    unique case (state_q)
                        ST_CMD: begin
                            addr_q  <= c_addr;
                            burst_q <= c_burst && !c_bad;
                            bad_q   <= c_bad;
                            rd_sh_q <= c_bad ? '0 : rd_data;
                        end
                        ST_WDATA: begin
                            if (!bad_q && (addr_q != STAT_ADDR)) begin
                                we_q <= 1'b1;
                            end
                            waddr_q <= addr_q;
                            wdata_q <= shifted;
                            addr_q  <= addr_q + 1'b1;
                        end
                        ST_RDATA: begin
                            rd_sh_q <= rd_data;
                            addr_q  <= addr_q + 1'b1;
                        end
                        default: ;
                    endcase
                end
                if (sclk_fall && (state_q == ST_RDATA)) begin
                    sdo_q   <= rd_sh_q[0];
                    rd_sh_q <= rd_sh_q >> 1;
                    oe_q    <= 1'b1;
                end
            end
        end
    end

    assign we     = we_q;
    assign waddr  = waddr_q;
    assign wdata  = wdata_q;
    assign sdo    = sdo_q;
    assign sdo_oe = oe_q;

    // R3: serial output only moves on a falling serial clock
    a_r3_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(sdo));

    // R4: never driving during command or write phases
    a_r4_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CMD) || (state_q == ST_WDATA)) |-> !sdo_oe);

    // R10: deselect returns to idle and releases the line
    a_r10_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> ((state_q == ST_IDLE) && !sdo_oe));

    // R9, R8: strobes only reach writable mapped registers
    a_r9_wr_legal: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> ((int'(waddr) < NREG) && (waddr != STAT_ADDR)));

endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
    parameter int NREG       = 14,
    parameter int DW         = 8,
    parameter int ADDR_W     = 4,
    parameter int STATUS_IDX = NREG - 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sclk,
    input  logic               sdi,
    input  logic [DW-1:0]      status_in,
    output logic               sdo,
    output logic               sdo_oe,
    output logic [NREG*DW-1:0] cfg_regs
);

    localparam int         NSYNC     = 3;
    localparam logic [2:0] SYNC_RST  = 3'b100; // cs_n idles high

    logic [NSYNC-1:0]  sync_q;
    logic [ADDR_W-1:0] rd_addr, waddr;
    logic [DW-1:0]     rd_data, wdata;
    logic              we;

    srp_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (NSYNC),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_n, sclk, sdi}),
        .sync_out (sync_q)
    );

    srp_ctrl #(
        .NREG       (NREG),
        .DW         (DW),
        .ADDR_W     (ADDR_W),
        .STATUS_IDX (STATUS_IDX)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (sync_q[2]),
        .sclk_s  (sync_q[1]),
        .sdi_s   (sync_q[0]),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe)
    );

    srp_regbank #(
        .NREG       (NREG),
        .DW         (DW),
        .ADDR_W     (ADDR_W),
        .STATUS_IDX (STATUS_IDX)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (we),
        .waddr     (waddr),
        .wdata     (wdata),
        .raddr     (rd_addr),
        .status_in (status_in),
        .rd_data   (rd_data),
        .regs_flat (cfg_regs)
    );

endmodule

// File: tb/serial_reg_port_tb_top.sv
module serial_reg_port_tb_top;

    localparam int NREG = 14;
    localparam int HALF = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              sclk = 1'b0;
    logic              sdi = 1'b0;
    logic [7:0]        status_in = 8'h00;
    logic              sdo, sdo_oe;
    logic [NREG*8-1:0] cfg_regs;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t       exp_q[$];
    logic [7:0] act_byte;
    event       got_byte;
    bit         oe_seen;

    always #4 clk = ~clk;

    serial_reg_port dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .status_in (status_in),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .cfg_regs  (cfg_regs)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // scoreboard monitor: pops the expected byte for every captured read byte
    initial begin
        forever begin
            @(got_byte);
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 32'(act_byte), 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, 32'(act_byte), 32'(e.val));
            end
        end
    end

    task automatic bit_xfer(input logic b, output logic o);
        @(negedge clk);
        sdi = b;
        repeat (HALF) @(negedge clk);
        o = sdo;
        if (sdo_oe) oe_seen = 1;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic start_txn();
        oe_seen = 0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic end_txn();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v);
        logic o;
        for (int i = 0; i < 8; i++) bit_xfer(v[i], o);
    endtask

    task automatic recv_byte(output logic [7:0] v);
        logic o;
        for (int i = 0; i < 8; i++) begin
            bit_xfer(1'b0, o);
            v[i] = o;
        end
    endtask

    function automatic logic [7:0] cmd(input logic rd, input logic [3:0] a,
                                       input logic [1:0] rsv, input logic burst);
        return {burst, rsv, a, rd};
    endfunction

    function automatic logic [7:0] reg_at(input int i);
        return cfg_regs[i*8 +: 8];
    endfunction

    task automatic wr_cmd(input logic [7:0] c, input logic [7:0] d, input string tag);
        start_txn();
        send_byte(c);
        send_byte(d);
        end_txn();
        check({tag, " oe low during write (R4)"}, 32'(oe_seen), 32'd0);
    endtask

    task automatic rd_cmd(input logic [7:0] c, input logic [7:0] exp, input string tag);
        logic [7:0] v;
        exp_q.push_back('{exp, tag});
        start_txn();
        send_byte(c);
        check({tag, " oe low in command (R4)"}, 32'(oe_seen), 32'd0);
        recv_byte(v);
        check({tag, " oe high in read data (R4)"}, 32'(sdo_oe), 32'd1);
        act_byte = v;
        -> got_byte;
        end_txn();
        check({tag, " oe low after deselect (R4)"}, 32'(sdo_oe), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check("watchdog expired", 32'd1, 32'd0);
        report();
    end

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R11: reset state
        check("R11 registers zero after reset", 32'(cfg_regs == '0), 32'd1);
        check("R11 oe low after reset", 32'(sdo_oe), 32'd0);

        // R2, R1: single write to register 3
        wr_cmd(cmd(1'b0, 4'd3, 2'b00, 1'b0), 8'hA5, "R2 write r3");
        check("R2 r3 holds A5", 32'(reg_at(3)), 32'hA5);
        check("R2 other registers untouched", 32'(cfg_regs & ~({{(NREG*8-32){1'b0}}, 32'hFF00_0000})), 32'd0);

        // R3, R1: single reads
        rd_cmd(cmd(1'b1, 4'd3, 2'b00, 1'b0), 8'hA5, "R3 read r3");
        wr_cmd(cmd(1'b0, 4'd0, 2'b00, 1'b0), 8'h3C, "R1 write r0");
        rd_cmd(cmd(1'b1, 4'd0, 2'b00, 1'b0), 8'h3C, "R1 read r0");
        wr_cmd(cmd(1'b0, 4'd8, 2'b00, 1'b0), 8'h81, "R1 write r8");
        check("R1 addr MSB r8", 32'(reg_at(8)), 32'h81);

        // R9: read-only status register
        status_in = 8'h5A;
        rd_cmd(cmd(1'b1, 4'd13, 2'b00, 1'b0), 8'h5A, "R9 read status");
        wr_cmd(cmd(1'b0, 4'd13, 2'b00, 1'b0), 8'hFF, "R9 write status");
        check("R9 status byte in cfg_regs zero", 32'(reg_at(13)), 32'h00);
        status_in = 8'hC3;
        rd_cmd(cmd(1'b1, 4'd13, 2'b00, 1'b0), 8'hC3, "R9 status follows input");

        // R7: malformed commands
        wr_cmd(cmd(1'b0, 4'd3, 2'b01, 1'b0), 8'h00, "R7 reserved write");
        check("R7 reserved write ignored", 32'(reg_at(3)), 32'hA5);
        rd_cmd(cmd(1'b1, 4'd3, 2'b10, 1'b0), 8'h00, "R7 reserved read zero");
        wr_cmd(cmd(1'b0, 4'd2, 2'b00, 1'b1), 8'h77, "R7 burst nonzero addr");
        check("R7 burst nonzero addr ignored", 32'(reg_at(2)), 32'h00);

        // R8: unmapped addresses
        wr_cmd(cmd(1'b0, 4'd14, 2'b00, 1'b0), 8'hEE, "R8 write addr 14");
        check("R8 map unchanged", 32'(reg_at(0) ^ reg_at(3) ^ reg_at(8)), 32'(8'h3C ^ 8'hA5 ^ 8'h81));
        rd_cmd(cmd(1'b1, 4'd15, 2'b00, 1'b0), 8'h00, "R8 read addr 15");

        // R5: burst write
        start_txn();
        send_byte(cmd(1'b0, 4'd0, 2'b00, 1'b1));
        for (int i = 0; i < NREG; i++) send_byte(8'(8'h10 + i));
        end_txn();
        check("R5 burst write oe low (R4)", 32'(oe_seen), 32'd0);
        for (int i = 0; i < NREG - 1; i++) check($sformatf("R5 burst write r%0d", i), 32'(reg_at(i)), 32'(8'h10 + i));
        check("R5 burst write skips status", 32'(reg_at(13)), 32'h00);

        // R6: burst read
        status_in = 8'h96;
        for (int i = 0; i < NREG; i++)
            exp_q.push_back('{(i == 13) ? 8'h96 : 8'(8'h10 + i), $sformatf("R6 burst read r%0d", i)});
        start_txn();
        send_byte(cmd(1'b1, 4'd0, 2'b00, 1'b1));
        for (int i = 0; i < NREG; i++) begin
            recv_byte(v);
            act_byte = v;
            -> got_byte;
            @(negedge clk);
        end
        end_txn();

        // R10: abort mid burst write
        start_txn();
        send_byte(cmd(1'b0, 4'd0, 2'b00, 1'b1));
        for (int i = 0; i < 3; i++) send_byte(8'(8'h80 + i));
        for (int i = 0; i < 4; i++) begin
            logic o;
            bit_xfer(1'b1, o);
        end
        end_txn();
        check("R10 r0 kept", 32'(reg_at(0)), 32'h80);
        check("R10 r2 kept", 32'(reg_at(2)), 32'h82);
        check("R10 r3 partial discarded", 32'(reg_at(3)), 32'h13);

        // R10: abort mid read releases output
        start_txn();
        send_byte(cmd(1'b1, 4'd1, 2'b00, 1'b0));
        for (int i = 0; i < 3; i++) begin
            logic o;
            bit_xfer(1'b0, o);
        end
        check("R10 oe high before abort", 32'(sdo_oe), 32'd1);
        end_txn();
        check("R10 oe low after abort", 32'(sdo_oe), 32'd0);
        rd_cmd(cmd(1'b1, 4'd1, 2'b00, 1'b0), 8'h81, "R10 fresh read after abort");

        check("scoreboard drained", 32'(exp_q.size()), 32'd0);
        report();
    end

endmodule